// File: doc/BRIEF.md
# Aperture-Based Address Remapper

This block sits in front of one bus master and rewrites every address it issues. The 32-bit address space is cut into sixteen equal windows of 256 MB, and the top four address bits choose the window. Each window carries two programmable 4-bit values. One names the target slave that the access is routed to. The other replaces the top nibble of the address, so a window can land on any 256 MB region of its target. The decode path is purely combinational. It returns the slave index, the rewritten address and an error flag for windows that lead nowhere.

Software programs the map through a small word-addressed register port. Four staging words hold the packed per-window fields. Writing those words has no effect on live traffic. The whole staged map moves into the live map in one step, when a 1 is written to a separate commit register. This lets the map be rebuilt without the decode ever seeing a half-written configuration.

Top module: `aperture_remap`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all readable registers return 0 and `decErr` is 1 for every master address.
- R2: A write to byte address 0x0, 0x4, 0x8 or 0xC updates only the staged word at that address, and that word is read back at the same address from the next cycle on.
- R3: A write to address 0x10 with data bit 0 equal to 1 copies all four staged words into the live map, and this takes effect from the next cycle. A write there with bit 0 equal to 0 changes nothing. Address 0x10 always reads 0.
- R4: The window index is `mstAddr[31:28]`. Window w takes its slave select from staged word 0x0 (w < 8) or 0x4 (w >= 8), at bits [4*(w mod 8)+3 : 4*(w mod 8)].
- R5: Window w takes its replacement nibble from word 0x8 (w < 8) or 0xC (w >= 8), at the same nibble position. `slvAddr[31:28]` is that nibble and `slvAddr[27:0]` equals `mstAddr[27:0]`.
- R6: `decErr` is 1 exactly when the live slave select of the addressed window is 0. `slvSel` always shows the live slave select. `slvAddr` carries no meaning while `decErr` is 1.
- R7: Writes to any address other than 0x0, 0x4, 0x8, 0xC or 0x10 are ignored, and reads of those addresses return 0.
- R8: Writes to the staging words leave `slvSel`, `slvAddr` and `decErr` unchanged until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| mstAddr | input | 32 | Address from the master |
| slvSel | output | 4 | Target slave index, 0 = none |
| slvAddr | output | 32 | Rewritten address |
| decErr | output | 1 | Window has no slave mapped |

## Verification
Register reads and the decode outputs are combinational from stored state, so both are due in the same cycle their inputs are applied. A staging write is visible on reads one edge after the write cycle. A commit reaches the decode outputs one edge after the commit cycle. The bench drives all inputs on the falling edge and samples 1 ns later, so every check reads settled values from the state that exists after the preceding rising edge. Its reference map is updated at the same falling edge at which the write is retired.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;

  // staged register slots: 0/1 slave-select words, 2/3 offset words
  localparam int unsigned REG_SLOTS = 4;
  localparam int unsigned SLOT_W    = $clog2(REG_SLOTS);

  typedef struct packed {
    logic              stageEn;   // write one staging word
    logic [SLOT_W-1:0] stageIdx;  // which staging word
    logic              commit;    // copy staged map to live map
    logic              rdHit;     // read address hits a staging word
    logic [SLOT_W-1:0] rdIdx;     // which staging word to return
  } remapStrobes_t;

endpackage

// File: rtl/aperture_remap_ctrl.sv
module aperture_remap_ctrl
  import aperture_remap_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output remapStrobes_t     strobes
);

  localparam int unsigned BYTE_LSB  = $clog2(DATA_W / 8);
  localparam int unsigned STAGE_END = REG_SLOTS * (DATA_W / 8);
  localparam logic [REG_AW-1:0] COMMIT_ADDR = REG_AW'(STAGE_END);

  logic aligned;
  logic inStage;

  always_comb begin
    aligned = (regAddr[BYTE_LSB-1:0] == '0);
    inStage = aligned && (regAddr < REG_AW'(STAGE_END));

    strobes.stageEn  = regWrEn && inStage;
    strobes.stageIdx = regAddr[BYTE_LSB +: SLOT_W];
    strobes.commit   = regWrEn && (regAddr == COMMIT_ADDR) && regWrData[0];
    strobes.rdHit    = inStage;
    strobes.rdIdx    = regAddr[BYTE_LSB +: SLOT_W];
  end

endmodule

// File: rtl/aperture_remap_datapath.sv
module aperture_remap_datapath
  import aperture_remap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned APER_BITS = 4,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  remapStrobes_t        strobes,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [ADDR_W-1:0]    mstAddr,
  output logic [SEL_W-1:0]     slvSel,
  output logic [ADDR_W-1:0]    slvAddr,
  output logic                 decErr
);

  localparam int unsigned NUM_APER  = 2 ** APER_BITS;
  localparam int unsigned PER_WORD  = DATA_W / SEL_W;
  localparam int unsigned SEL_WORDS = NUM_APER / PER_WORD;
  localparam int unsigned LOW_W     = ADDR_W - APER_BITS;

  logic [DATA_W-1:0] staged [REG_SLOTS];
  logic [DATA_W-1:0] active [REG_SLOTS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < REG_SLOTS; s++) begin
        staged[s] <= '0;
        active[s] <= '0;
      end
    end else begin
      if (strobes.stageEn) staged[strobes.stageIdx] <= regWrData;
      if (strobes.commit) begin
        for (int s = 0; s < REG_SLOTS; s++) active[s] <= staged[s];
      end
    end
  end

  logic [SEL_W-1:0]     apSel [NUM_APER];
  logic [APER_BITS-1:0] apOff [NUM_APER];

  for (genvar a = 0; a < NUM_APER; a++) begin : g_unpack
    localparam int unsigned WORD = a / PER_WORD;
    localparam int unsigned POS  = (a % PER_WORD) * SEL_W;
    assign apSel[a] = active[WORD][POS +: SEL_W];
    assign apOff[a] = active[SEL_WORDS + WORD][POS +: APER_BITS];
  end

  logic [APER_BITS-1:0] apIdx;

  always_comb begin
    apIdx   = mstAddr[ADDR_W-1 -: APER_BITS];
    slvSel  = apSel[apIdx];
    decErr  = (slvSel == '0);
    slvAddr = {apOff[apIdx], mstAddr[LOW_W-1:0]};
    regRdData = strobes.rdHit ? staged[strobes.rdIdx] : '0;
  end

endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import aperture_remap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_AW    = 5,
  parameter int unsigned APER_BITS = 4,
  parameter int unsigned SEL_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] mstAddr,
  output logic [SEL_W-1:0]  slvSel,
  output logic [ADDR_W-1:0] slvAddr,
  output logic              decErr
);

  remapStrobes_t strobes;

  aperture_remap_ctrl #(
    .REG_AW(REG_AW),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobes  (strobes)
  );

  aperture_remap_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .APER_BITS(APER_BITS),
    .SEL_W    (SEL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .mstAddr  (mstAddr),
    .slvSel   (slvSel),
    .slvAddr  (slvAddr),
    .decErr   (decErr)
  );

endmodule

// File: rtl/aperture_remap_chk.sv
module aperture_remap_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_AW    = 5,
  parameter int unsigned APER_BITS = 4,
  parameter int unsigned SEL_W     = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [ADDR_W-1:0] mstAddr,
  input logic [SEL_W-1:0]  slvSel,
  input logic [ADDR_W-1:0] slvAddr,
  input logic              decErr
);

  localparam logic [REG_AW-1:0] COMMIT_ADDR = REG_AW'(16);
  localparam int unsigned LOW_W = ADDR_W - APER_BITS;

  logic commitReq;
  logic stageHit;
  assign commitReq = regWrEn && (regAddr == COMMIT_ADDR) && regWrData[0];
  assign stageHit  = (regAddr[1:0] == 2'b00) && (regAddr < COMMIT_ADDR);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (decErr && regRdData == '0));

  // R3
  commit_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == COMMIT_ADDR) |-> (regRdData == '0));

  // R8
  live_map_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(commitReq) && $stable(mstAddr)) |->
      ($stable(slvSel) && $stable(decErr) && $stable(slvAddr)));

  // R2
  stage_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn) && $past(stageHit) && regAddr == $past(regAddr))
      |-> (regRdData == $past(regWrData)));

  // R5
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decErr |-> (slvAddr[LOW_W-1:0] == mstAddr[LOW_W-1:0]));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stageHit) |-> (regRdData == '0));

endmodule

bind aperture_remap aperture_remap_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW),
  .APER_BITS(APER_BITS), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/aperture_remap_bench.sv
`timescale 1ns/1ps
module aperture_remap_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] mstAddr = '0;
  logic [3:0]  slvSel;
  logic [31:0] slvAddr;
  logic        decErr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mStaged [4];
  logic [31:0] mActive [4];

  always #5 clk = ~clk;

  aperture_remap u_aperture_remap (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mstAddr(mstAddr),
    .slvSel(slvSel), .slvAddr(slvAddr), .decErr(decErr)
  );

  function automatic logic [3:0] expSel(input logic [31:0] a);
    int w = int'(a[31:28]);
    return mActive[w / 8][(w % 8) * 4 +: 4];
  endfunction

  function automatic logic [3:0] expOff(input logic [31:0] a);
    int w = int'(a[31:28]);
    return mActive[2 + w / 8][(w % 8) * 4 +: 4];
  endfunction

  function automatic logic [31:0] expRead(input logic [4:0] a);
    if (a[1:0] == 2'b00 && a < 5'd16) return mStaged[a[3:2]];
    return '0;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a[1:0] == 2'b00 && a < 5'd16) mStaged[a[3:2]] = d;
    else if (a == 5'd16 && d[0]) begin
      for (int s = 0; s < 4; s++) mActive[s] = mStaged[s];
    end
  endtask

  task automatic chkRd(input logic [4:0] a, input string req);
    logic [31:0] e;
    regAddr = a;
    #1;
    e = expRead(a);
    checks++;
    if (regRdData !== e) begin
      fails++;
      $display("FAIL %s read 0x%0h: actual %h expected %h", req, a, regRdData, e);
    end
  endtask

  task automatic chkDec(input logic [31:0] a, input string req);
    logic [3:0] es;
    logic [31:0] ea;
    mstAddr = a;
    #1;
    es = expSel(a);
    ea = {expOff(a), a[27:0]};
    checks++;
    if (decErr !== (es == 4'd0) || slvSel !== es ||
        (es != 4'd0 && slvAddr !== ea)) begin
      fails++;
      $display("FAIL %s addr %h: actual sel=%h err=%b out=%h expected sel=%h err=%b out=%h",
               req, a, slvSel, decErr, slvAddr, es, (es == 4'd0), ea);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 4; s++) begin mStaged[s] = '0; mActive[s] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: state after reset
    for (int r = 0; r < 6; r++) chkRd(5'(r * 4), "R1");
    chkDec(32'h0000_0000, "R1");
    chkDec(32'hF123_4567, "R1");
    chkDec(32'h8000_0010, "R1");

    // R2, R8: stage a full map, live decode untouched
    wr(5'h00, 32'h7654_3210);
    wr(5'h04, 32'h0FED_CBA9);
    wr(5'h08, 32'h89AB_CDEF);
    wr(5'h0C, 32'h1357_9BDF);
    chkRd(5'h00, "R2"); chkRd(5'h04, "R2");
    chkRd(5'h08, "R2"); chkRd(5'h0C, "R2");
    chkDec(32'h1000_0000, "R8");
    chkDec(32'h9ABC_DEF0, "R8");

    // R3 with bit0 clear: no commit
    wr(5'h10, 32'hFFFF_FFFE);
    chkDec(32'h1000_0000, "R3");
    chkRd(5'h10, "R3");

    // R3 commit, then R4/R5/R6 over every window
    wr(5'h10, 32'h0000_0001);
    for (int w = 0; w < 16; w++) chkDec({w[3:0], 28'h5A5_A5A5}, "R4");
    chkDec(32'h0FFF_FFFF, "R6");
    chkDec(32'hF000_0001, "R5");

    // R8: later staging writes do not reach the live map
    wr(5'h00, 32'h0000_0000);
    chkDec(32'h1234_5678, "R8");
    chkRd(5'h00, "R2");

    // R7: writes elsewhere ignored, reads zero
    wr(5'h14, 32'hDEAD_BEEF);
    wr(5'h02, 32'hCAFE_F00D);
    wr(5'h1C, 32'h1111_1111);
    chkRd(5'h14, "R7"); chkRd(5'h02, "R7"); chkRd(5'h1F, "R7");
    chkRd(5'h00, "R7"); chkRd(5'h04, "R7");
    chkDec(32'h3000_0000, "R7");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a;
      logic [31:0] d;
      int pick = int'($urandom_range(0, 9));
      if (pick < 6) a = 5'(pick < 4 ? pick * 4 : 16);
      else a = 5'($urandom_range(0, 31));
      d = $urandom();
      if (a == 5'd16 && pick == 5) d[0] = 1'b1;
      wr(a, d);
      chkRd(5'($urandom_range(0, 31)), "R2");
      chkDec($urandom(), "R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule